// File: doc/BRIEF.md
# Single-Port Synchronous RAM with Selectable Read-During-Write Behaviour

This block is a single-port memory with a clocked write and a clocked read. It has one address. A port enable gates both operations. When the enable is high and the write enable is also high, the word at that address is replaced on the clock edge. The registered read output always changes on a clock edge, and its value in a write cycle is set at compile time by a parameter. The parameter can return the word that was stored before the write, the word being written, or nothing new (the output keeps its last value). The parameter is encoded as 0 for read-before-write, 1 for write-through and 2 for hold-on-write.

A second parameter inserts an extra output register. This register has its own load enable. It trades one cycle of read latency for a shorter clock-to-output path. A synchronous active-high reset clears the output register stages. It never clears the stored words. Integrators pick the mode to suit the consumer: a read-modify-write pipeline wants the old word, a forwarding path wants the new one, and a consumer that must not see write traffic uses hold-on-write.

Top module: `sram_wmode`

## Requirements
- R1: While `rst` is high at a clock edge, both output stages are cleared to zero, so `rdata` reads zero on the following cycle.
- R2: A clock edge with `en`=1 and `we`=1 stores `wdata` at `addr`. A later read of that address returns it.
- R3: A clock edge with `en`=0 neither writes the memory nor changes the first output stage, whatever `we`, `addr` and `wdata` carry.
- R4: With `WMODE`=0 (read-before-write), a write cycle loads the first output stage with the word held at `addr` before the write.
- R5: With `WMODE`=1 (write-through), a write cycle loads the first output stage with `wdata`.
- R6: With `WMODE`=2 (hold-on-write), a write cycle leaves the first output stage unchanged.
- R7: A read cycle (`en`=1, `we`=0) loads the first output stage with the word at `addr`. With `OUT_REG`=0 this word appears on `rdata` after that single edge.
- R8: With `OUT_REG`=1, `rdata` comes from a second register. That register copies the first stage on an edge where `pipe_ce`=1 and holds where `pipe_ce`=0, so read latency is two edges.
- R9: Reset leaves the stored words intact. A read after reset returns the data written before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every operation happens on its rising edge |
| rst | input | 1 | Synchronous active-high reset of the output registers |
| en | input | 1 | Port enable gating both write and read |
| we | input | 1 | Write enable, active high, qualified by `en` |
| addr | input | ADDR_W | Word address for both write and read |
| wdata | input | DATA_W | Data to store |
| pipe_ce | input | 1 | Load enable of the optional extra output register |
| rdata | output | DATA_W | Registered read data |

## Verification
A write and a read of the same word fall in the same cycle on every write edge. The mode decides which of the two the output shows. The bench drives identical stimulus into three instances, one per mode. It rewrites addresses whose old contents are known, so that the old word, the new word and the previously held output are three distinct values. One compare therefore tells the modes apart. A separate case asserts reset and a pipeline load together in one edge and expects zero to win.

// File: rtl/sram_wmode_pkg.sv
package sram_wmode_pkg;

    typedef enum logic [1:0] {
        WM_OLD  = 2'd0,
        WM_NEW  = 2'd1,
        WM_HOLD = 2'd2
    } wmode_e;

    function automatic wmode_e to_mode(input int code);
        case (code)
            1:       return WM_NEW;
            2:       return WM_HOLD;
            default: return WM_OLD;
        endcase
    endfunction

    function automatic logic stage_loads(input wmode_e m, input logic en, input logic we);
        if (!en)
            return 1'b0;
        if (we && m == WM_HOLD)
            return 1'b0;
        return 1'b1;
    endfunction

endpackage

// File: rtl/sram_array.sv
module sram_array #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] word
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (wr)
            cells[addr] <= wdata;
    end

    assign word = cells[addr];
endmodule

// File: rtl/sram_read_sel.sv
module sram_read_sel
    import sram_wmode_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int WMODE  = 0
) (
    input  logic              en,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] stored,
    output logic              load,
    output logic [DATA_W-1:0] next_q
);
    localparam wmode_e MODE_E = to_mode(WMODE);

    assign load = stage_loads(MODE_E, en, we);

    generate
        if (MODE_E == WM_NEW) begin : g_fwd
            assign next_q = we ? wdata : stored;
        end else begin : g_mem
            assign next_q = stored;
        end
    endgenerate
endmodule

// File: rtl/sram_out_stage.sv
module sram_out_stage #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce,
    input  logic [DATA_W-1:0] d,
    output logic [DATA_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (ce)
            q <= d;
    end
endmodule

// File: rtl/sram_wmode.sv
module sram_wmode #(
    parameter int DATA_W  = 16,
    parameter int ADDR_W  = 5,
    parameter int WMODE   = 0,
    parameter bit OUT_REG = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              pipe_ce,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] stored;
    logic [DATA_W-1:0] next_q;
    logic [DATA_W-1:0] stage_q;
    logic              stage_ld;

    sram_array #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_array (
        .clk   (clk),
        .wr    (en & we),
        .addr  (addr),
        .wdata (wdata),
        .word  (stored)
    );

    sram_read_sel #(.DATA_W(DATA_W), .WMODE(WMODE)) u_sel (
        .en     (en),
        .we     (we),
        .wdata  (wdata),
        .stored (stored),
        .load   (stage_ld),
        .next_q (next_q)
    );

    sram_out_stage #(.DATA_W(DATA_W)) u_stage1 (
        .clk (clk),
        .rst (rst),
        .ce  (stage_ld),
        .d   (next_q),
        .q   (stage_q)
    );

    generate
        if (OUT_REG) begin : g_pipe
            logic [DATA_W-1:0] pipe_q;
            sram_out_stage #(.DATA_W(DATA_W)) u_stage2 (
                .clk (clk),
                .rst (rst),
                .ce  (pipe_ce),
                .d   (stage_q),
                .q   (pipe_q)
            );
            assign rdata = pipe_q;
        end else begin : g_direct
            logic unused_ce;
            assign unused_ce = pipe_ce;
            assign rdata = stage_q;
        end
    endgenerate
endmodule

// File: rtl/sram_wmode_chk.sv
module sram_wmode_chk #(
    parameter int DATA_W  = 16,
    parameter int WMODE   = 0,
    parameter bit OUT_REG = 1'b0
) (
    input logic              clk,
    input logic              rst,
    input logic              en,
    input logic              we,
    input logic [DATA_W-1:0] wdata,
    input logic              pipe_ce,
    input logic [DATA_W-1:0] q1,
    input logic [DATA_W-1:0] rdata
);
    // R1
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (q1 == '0 && rdata == '0));

    // R3
    a_r3_idle_holds: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(q1));

    // R5
    a_r5_write_through: assert property (@(posedge clk) disable iff (rst)
        (WMODE == 1 && en && we) |=> q1 == $past(wdata));

    // R6
    a_r6_hold_on_write: assert property (@(posedge clk) disable iff (rst)
        (WMODE == 2 && en && we) |=> $stable(q1));

    // R8
    a_r8_pipe_holds: assert property (@(posedge clk) disable iff (rst)
        (OUT_REG && !pipe_ce) |=> $stable(rdata));

    // R8
    a_r8_pipe_loads: assert property (@(posedge clk) disable iff (rst)
        (OUT_REG && pipe_ce) |=> rdata == $past(q1));
endmodule

bind sram_wmode sram_wmode_chk #(
    .DATA_W (DATA_W),
    .WMODE  (WMODE),
    .OUT_REG(OUT_REG)
) i_chk (
    .clk    (clk),
    .rst    (rst),
    .en     (en),
    .we     (we),
    .wdata  (wdata),
    .pipe_ce(pipe_ce),
    .q1     (stage_q),
    .rdata  (rdata)
);

// File: tb/test_sram_wmode.sv
module test_sram_wmode;
    localparam int DW = 16;
    localparam int AW = 5;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          en = 1'b0;
    logic          we = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic          pipe_ce = 1'b0;
    logic [DW-1:0] rd_old, rd_new, rd_hold, rd_pipe;

    int n_vec = 0;
    int n_bad = 0;

    logic [DW-1:0] m_mem [DEPTH];
    logic [DW-1:0] m_old, m_new, m_hold, m_pipe;

    always #10 clk = ~clk;

    sram_wmode #(.DATA_W(DW), .ADDR_W(AW), .WMODE(0), .OUT_REG(1'b0)) i_sram_wmode (
        .clk(clk), .rst(rst), .en(en), .we(we), .addr(addr), .wdata(wdata),
        .pipe_ce(pipe_ce), .rdata(rd_old));
    sram_wmode #(.DATA_W(DW), .ADDR_W(AW), .WMODE(1), .OUT_REG(1'b0)) i_sram_wmode_new (
        .clk(clk), .rst(rst), .en(en), .we(we), .addr(addr), .wdata(wdata),
        .pipe_ce(pipe_ce), .rdata(rd_new));
    sram_wmode #(.DATA_W(DW), .ADDR_W(AW), .WMODE(2), .OUT_REG(1'b0)) i_sram_wmode_hold (
        .clk(clk), .rst(rst), .en(en), .we(we), .addr(addr), .wdata(wdata),
        .pipe_ce(pipe_ce), .rdata(rd_hold));
    sram_wmode #(.DATA_W(DW), .ADDR_W(AW), .WMODE(0), .OUT_REG(1'b1)) i_sram_wmode_pipe (
        .clk(clk), .rst(rst), .en(en), .we(we), .addr(addr), .wdata(wdata),
        .pipe_ce(pipe_ce), .rdata(rd_pipe));

    task automatic chk(input string tag, input string what, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic chk_all(input string tag);
        chk(tag, "old-mode", rd_old, m_old);
        chk(tag, "new-mode", rd_new, m_new);
        chk(tag, "hold-mode", rd_hold, m_hold);
        chk(tag, "piped", rd_pipe, m_pipe);
    endtask

    // one clock: drive at negedge, update model at posedge, sample 5 ns later
    task automatic step(input logic r, input logic e, input logic w, input int a,
                        input logic [DW-1:0] d, input logic p);
        logic [DW-1:0] word;
        logic [DW-1:0] prev_old;
        @(negedge clk);
        rst = r; en = e; we = w; addr = AW'(a); wdata = d; pipe_ce = p;
        @(posedge clk);
        word = m_mem[a];
        prev_old = m_old;
        if (r) begin
            m_old = '0; m_new = '0; m_hold = '0; m_pipe = '0;
        end else begin
            if (p) m_pipe = prev_old;
            if (e) begin
                m_old = word;
                m_new = w ? d : word;
                if (!w) m_hold = word;
            end
        end
        if (e && w) m_mem[a] = d;
        #5;
    endtask

    task automatic t_reset();
        step(1, 0, 0, 0, '0, 1);
        chk_all("R1 reset state");
    endtask

    task automatic t_fill();
        // R2: fill every word; R5 write-through shows written data
        for (int i = 0; i < DEPTH; i++) begin
            step(0, 1, 1, i, DW'(16'h1000 + i * 16'h0101), 0);
            chk("R5", "new-mode during fill", rd_new, m_new);
            chk("R6", "hold-mode during fill", rd_hold, m_hold);
        end
        step(0, 1, 0, 3, '0, 0);
        chk_all("R2 R7 read after fill");
    endtask

    task automatic t_modes();
        step(0, 1, 0, 7, '0, 0);
        chk_all("R7 read");
        step(0, 1, 1, 9, 16'hBEEF, 0);
        chk("R4", "old word on write", rd_old, 16'h1000 + 9 * 16'h0101);
        chk("R5", "new word on write", rd_new, 16'hBEEF);
        chk("R6", "held on write", rd_hold, 16'h1000 + 7 * 16'h0101);
        step(0, 1, 1, 9, 16'hCAFE, 0);
        chk("R4", "second write old word", rd_old, 16'hBEEF);
        chk_all("R4 R5 R6 back-to-back write");
        step(0, 1, 0, 9, '0, 0);
        chk_all("R2 R7 read back");
    endtask

    task automatic t_disabled();
        step(0, 0, 1, 12, 16'hDEAD, 0);
        chk_all("R3 disabled write");
        step(0, 0, 0, 20, '0, 0);
        chk_all("R3 disabled read");
        step(0, 1, 0, 12, '0, 0);
        chk("R3", "word untouched", rd_old, 16'h1000 + 12 * 16'h0101);
        chk_all("R3 R7 readback");
    endtask

    task automatic t_pipe();
        step(0, 1, 0, 4, '0, 1);
        chk("R8", "pipe has earlier word", rd_pipe, 16'h1000 + 12 * 16'h0101);
        step(0, 1, 0, 5, '0, 1);
        chk("R8", "pipe two-edge latency", rd_pipe, 16'h1000 + 4 * 16'h0101);
        step(0, 1, 0, 6, '0, 0);
        chk("R8", "pipe holds with ce low", rd_pipe, 16'h1000 + 4 * 16'h0101);
        step(0, 0, 0, 6, '0, 1);
        chk("R8", "pipe loads with ce high", rd_pipe, 16'h1000 + 6 * 16'h0101);
        chk_all("R8 all");
    endtask

    task automatic t_reset_keeps();
        step(1, 1, 0, 9, '0, 1);
        chk_all("R1 reset over read");
        step(0, 1, 0, 9, '0, 0);
        chk("R9", "word survives reset", rd_old, 16'hCAFE);
        step(0, 1, 0, 31, '0, 1);
        chk("R9", "top word survives", rd_old, 16'h1000 + 31 * 16'h0101);
        chk_all("R9 all");
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;
        m_old = '0; m_new = '0; m_hold = '0; m_pipe = '0;
        t_reset();
        t_fill();
        t_modes();
        t_disabled();
        t_pipe();
        t_reset_keeps();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(20 * 100000);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule